// File: doc/BRIEF.md
# Synthesizer divider programming interface

This block holds the divider settings of a frequency synthesizer and lets a host load them in one of three ways: a serial bit stream with its own clock, an 8-bit bus with three slice strobes, or a set of static pins. It keeps a 20-bit primary word, which holds the reference divider, the main divider, the prescaler enable and the swallow count. It also keeps an 8-bit auxiliary control register that can be masked by an active-low enable pin.

All host inputs are asynchronous to the block. Each one passes through a two-flop synchronizer into the system clock domain, and edges are found from the synchronized samples. Serial shifting and the transfer into a holding register are separate actions, each with its own strobe, so the outputs never ripple while bits are being shifted in. The primary stream and the auxiliary stream use separate shift registers, which share the serial data and clock pins. The level of the auxiliary strobe selects which of the two shift registers takes each bit.

Top module: `synth_prog_if`

## Requirements
- R1: While rst_ni is low, every output is 0, and both holding registers and both shift registers are cleared to zero.
- R2: The load mode is picked as follows. direct_sel_i high selects direct mode. Otherwise serial_sel_i high selects serial mode and serial_sel_i low selects parallel mode. A primary strobe that does not belong to the current mode leaves the outputs unchanged: prim_xfer_i has no effect in parallel mode, and the wr_* strobes have no effect in serial mode.
- R3: In serial mode, on each rising ser_clk_i while aux_wr_i is low, the value of ser_dat_i enters the primary shift register. The first bit sent is the word's bit 19. A rising prim_xfer_i copies the 20 shifted bits into the primary word. The outputs do not change before that copy.
- R4: Primary word layout, from bit 19 down to bit 0: ref[5], ref[4], main[8], main[7], prescaler enable, main[6:0], ref[3:0], swallow[3:0]. The outputs ref_div_o, main_div_o, presc_en_o and swal_o present these fields.
- R5: In parallel mode, a rising wr_top_i loads bus_i[3:0] into word bits 19:16. A rising wr_main_i loads bus_i into bits 15:8. A rising wr_low_i loads bus_i into bits 7:0. The other bits keep their values.
- R6: In direct mode, word bits 15:0 follow pin_word_i, and bits 19:16 (ref[5:4] and main[8:7]) are held at 0.
- R7: In serial mode, on each rising ser_clk_i while aux_wr_i is high, the value of ser_dat_i enters the auxiliary shift register, MSB first. The auxiliary register takes the shifted byte on the falling edge of aux_wr_i, and its outputs are unchanged until that edge.
- R8: In parallel mode, a rising aux_wr_i loads bus_i into the auxiliary register.
- R9: aux_ctrl_o shows the auxiliary register while aux_en_ni is low, and is 0 while aux_en_ni is high.
- R10: Shifting auxiliary bits does not disturb the primary shift register. A primary transfer made after an auxiliary sequence delivers the 20 primary bits that were shifted before that sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| direct_sel_i | input | 1 | High selects direct mode |
| serial_sel_i | input | 1 | High selects serial mode, low selects parallel mode |
| aux_en_ni | input | 1 | Active-low enable of aux_ctrl_o |
| ser_dat_i | input | 1 | Serial data |
| ser_clk_i | input | 1 | Serial shift clock |
| prim_xfer_i | input | 1 | Serial primary transfer strobe |
| aux_wr_i | input | 1 | Auxiliary strobe: selects the shift target and performs the capture |
| bus_i | input | 8 | Parallel data bus |
| wr_top_i | input | 1 | Parallel strobe for word bits 19:16 |
| wr_main_i | input | 1 | Parallel strobe for word bits 15:8 |
| wr_low_i | input | 1 | Parallel strobe for word bits 7:0 |
| pin_word_i | input | 16 | Direct-mode pins for word bits 15:0 |
| ref_div_o | output | 6 | Reference divider field |
| main_div_o | output | 9 | Main divider field |
| swal_o | output | 4 | Swallow counter field |
| presc_en_o | output | 1 | Prescaler enable bit |
| aux_ctrl_o | output | 8 | Masked auxiliary control bits |

## Verification
The primary word is loaded in each mode with several distinct values. The patterns differ in every field and include all-ones and alternating words, so a swapped, shifted or dropped field mapping shows up. Parallel strobes are issued one at a time, which separates the slices, and upper-bit patterns applied in direct mode expose a missing force to zero. Auxiliary sequences are checked in the middle of shifting, after capture, and both masked and unmasked. A strobe from the wrong mode, and an auxiliary sequence placed between a primary shift and its transfer, show whether the modes and the two shift paths stay apart.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int unsigned WORD_W = 20;
  localparam int unsigned PIN_W  = 16;
  localparam int unsigned REF_W  = 6;
  localparam int unsigned MAIN_W = 9;
  localparam int unsigned SWAL_W = 4;
  localparam int unsigned CTL_W  = 10;

  typedef enum logic [1:0] {
    MODE_PAR = 2'd0,
    MODE_SER = 2'd1,
    MODE_DIR = 2'd2
  } load_mode_e;

  typedef struct packed {
    logic direct_sel;
    logic serial_sel;
    logic aux_en_n;
    logic ser_dat;
    logic ser_clk;
    logic prim_xfer;
    logic aux_wr;
    logic wr_top;
    logic wr_main;
    logic wr_low;
  } ctl_t;
endpackage

// File: rtl/synth_prog_sync.sv
module synth_prog_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign q_o      = s2_q;
  assign q_prev_o = s3_q;
endmodule

// File: rtl/synth_prog_shift.sv
module synth_prog_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sh_q <= '0;
    else if (en_i) sh_q <= {sh_q[W-2:0], d_i};
  end

  assign q_o = sh_q;

  // new bit lands in LSB, older bits move up
  assert_shift_in_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (sh_q[0] == $past(d_i)) && (sh_q[W-1:1] == $past(sh_q[W-2:0])));
  assert_shift_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(sh_q));
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import synth_prog_pkg::*;
#(
  parameter int unsigned BUS_W = 8,
  parameter int unsigned ENH_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              direct_sel_i,
  input  logic              serial_sel_i,
  input  logic              aux_en_ni,
  input  logic              ser_dat_i,
  input  logic              ser_clk_i,
  input  logic              prim_xfer_i,
  input  logic              aux_wr_i,
  input  logic [BUS_W-1:0]  bus_i,
  input  logic              wr_top_i,
  input  logic              wr_main_i,
  input  logic              wr_low_i,
  input  logic [PIN_W-1:0]  pin_word_i,
  output logic [REF_W-1:0]  ref_div_o,
  output logic [MAIN_W-1:0] main_div_o,
  output logic [SWAL_W-1:0] swal_o,
  output logic              presc_en_o,
  output logic [ENH_W-1:0]  aux_ctrl_o
);
  localparam int unsigned SYNC_W = CTL_W + BUS_W + PIN_W;
  localparam int unsigned UP_W   = WORD_W - PIN_W;

  ctl_t             ctl_in, ctl_s, ctl_p;
  logic [BUS_W-1:0] bus_s, bus_p;
  logic [PIN_W-1:0] pin_s, pin_p;

  assign ctl_in = '{direct_sel: direct_sel_i, serial_sel: serial_sel_i,
                    aux_en_n: aux_en_ni, ser_dat: ser_dat_i, ser_clk: ser_clk_i,
                    prim_xfer: prim_xfer_i, aux_wr: aux_wr_i, wr_top: wr_top_i,
                    wr_main: wr_main_i, wr_low: wr_low_i};

  synth_prog_sync #(.W(SYNC_W)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .d_i      ({ctl_in, bus_i, pin_word_i}),
    .q_o      ({ctl_s, bus_s, pin_s}),
    .q_prev_o ({ctl_p, bus_p, pin_p})
  );

  logic sclk_rise, xfer_rise, aux_rise, aux_fall, top_rise, main_rise, low_rise;
  assign sclk_rise = ctl_s.ser_clk   & ~ctl_p.ser_clk;
  assign xfer_rise = ctl_s.prim_xfer & ~ctl_p.prim_xfer;
  assign aux_rise  = ctl_s.aux_wr    & ~ctl_p.aux_wr;
  assign aux_fall  = ~ctl_s.aux_wr   &  ctl_p.aux_wr;
  assign top_rise  = ctl_s.wr_top    & ~ctl_p.wr_top;
  assign main_rise = ctl_s.wr_main   & ~ctl_p.wr_main;
  assign low_rise  = ctl_s.wr_low    & ~ctl_p.wr_low;

  load_mode_e mode;
  always_comb begin
    if (ctl_s.direct_sel)      mode = MODE_DIR;
    else if (ctl_s.serial_sel) mode = MODE_SER;
    else                       mode = MODE_PAR;
  end

  // separate shift paths; aux_wr level steers the bit
  logic              pri_sh_en, enh_sh_en;
  logic [WORD_W-1:0] pri_sh;
  logic [ENH_W-1:0]  enh_sh;
  assign pri_sh_en = (mode == MODE_SER) & sclk_rise & ~ctl_s.aux_wr;
  assign enh_sh_en = ctl_s.serial_sel & sclk_rise & ctl_s.aux_wr;

  synth_prog_shift #(.W(WORD_W)) u_pri_sh (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (pri_sh_en),
    .d_i (ctl_s.ser_dat), .q_o (pri_sh)
  );

  synth_prog_shift #(.W(ENH_W)) u_enh_sh (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (enh_sh_en),
    .d_i (ctl_s.ser_dat), .q_o (enh_sh)
  );

  logic [WORD_W-1:0] word_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
    end else begin
      unique case (mode)
        MODE_DIR: word_q <= {{UP_W{1'b0}}, pin_s};
        MODE_SER: if (xfer_rise) word_q <= pri_sh;
        default: begin
          if (top_rise)  word_q[WORD_W-1:PIN_W] <= bus_s[UP_W-1:0];
          if (main_rise) word_q[PIN_W-1:BUS_W]  <= bus_s;
          if (low_rise)  word_q[BUS_W-1:0]      <= bus_s;
        end
      endcase
    end
  end

  // auxiliary holding register: serial capture on falling strobe, parallel on rising
  logic [ENH_W-1:0] enh_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          enh_q <= '0;
    else if (ctl_s.serial_sel && aux_fall) enh_q <= enh_sh;
    else if (!ctl_s.serial_sel && aux_rise) enh_q <= bus_s;
  end

  assign ref_div_o  = {word_q[19:18], word_q[7:4]};
  assign main_div_o = {word_q[17:16], word_q[14:8]};
  assign presc_en_o = word_q[15];
  assign swal_o     = word_q[3:0];
  assign aux_ctrl_o = ctl_s.aux_en_n ? '0 : enh_q;

  assert_direct_upper_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_DIR) |=> (ref_div_o[5:4] == 2'b00) && (main_div_o[8:7] == 2'b00));
  assert_ser_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode == MODE_SER) && !xfer_rise) |=> $stable(word_q));
  assert_enh_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_s.serial_sel && !aux_fall) |=> $stable(enh_q));
  assert_par_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode == MODE_PAR) && !top_rise && !main_rise && !low_rise) |=> $stable(word_q));
endmodule

// File: tb/synth_prog_if_tb.sv
module synth_prog_if_tb;
  logic clk_i = 0, rst_ni = 0;
  logic direct_sel_i = 0, serial_sel_i = 0, aux_en_ni = 0;
  logic ser_dat_i = 0, ser_clk_i = 0, prim_xfer_i = 0, aux_wr_i = 0;
  logic [7:0] bus_i = 0;
  logic wr_top_i = 0, wr_main_i = 0, wr_low_i = 0;
  logic [15:0] pin_word_i = 0;
  logic [5:0] ref_div_o;
  logic [8:0] main_div_o;
  logic [3:0] swal_o;
  logic presc_en_o;
  logic [7:0] aux_ctrl_o;

  int checks = 0, errors = 0;
  logic [19:0] exp_w;

  always #10 clk_i = ~clk_i;

  synth_prog_if u_dut (.*);

  function automatic logic [19:0] out_word();
    return {ref_div_o[5:4], main_div_o[8:7], presc_en_o, main_div_o[6:0],
            ref_div_o[3:0], swal_o};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(posedge clk_i);
    #3;
  endtask

  task automatic pulse(ref logic s);
    s = 1; wclk(5); s = 0; wclk(5);
  endtask

  task automatic ser_bit(logic b);
    ser_dat_i = b; wclk(3);
    ser_clk_i = 1; wclk(4);
    ser_clk_i = 0; wclk(4);
  endtask

  task automatic ser_word(logic [19:0] w);
    for (int i = 19; i >= 0; i--) ser_bit(w[i]);
  endtask

  task automatic ser_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) ser_bit(b[i]);
  endtask

  task automatic t_reset();
    chk("R1 word", out_word(), 0);
    chk("R1 aux", aux_ctrl_o, 0);
  endtask

  task automatic t_parallel(logic [19:0] w);
    direct_sel_i = 0; serial_sel_i = 0; wclk(4);
    bus_i = {4'h0, w[19:16]}; wclk(3); pulse(wr_top_i);
    exp_w[19:16] = w[19:16];
    chk("R5 top", out_word(), exp_w);
    bus_i = w[15:8]; wclk(3); pulse(wr_main_i);
    exp_w[15:8] = w[15:8];
    chk("R5 main", out_word(), exp_w);
    bus_i = w[7:0]; wclk(3); pulse(wr_low_i);
    exp_w[7:0] = w[7:0];
    chk("R4 fields", out_word(), exp_w);
    chk("R4 presc", presc_en_o, w[15]);
  endtask

  task automatic t_serial(logic [19:0] w);
    direct_sel_i = 0; serial_sel_i = 1; aux_wr_i = 0; wclk(4);
    ser_word(w);
    chk("R3 hold before xfer", out_word(), exp_w);
    pulse(prim_xfer_i);
    exp_w = w;
    chk("R3 xfer", out_word(), exp_w);
  endtask

  task automatic t_direct(logic [15:0] p);
    direct_sel_i = 1; pin_word_i = p; wclk(6);
    exp_w = {4'h0, p};
    chk("R6 direct", out_word(), exp_w);
    pin_word_i = ~p; wclk(6);
    exp_w = {4'h0, ~p};
    chk("R6 follow", out_word(), exp_w);
    bus_i = 8'hFF; pulse(wr_top_i);
    chk("R6 upper zero", out_word(), exp_w);
    direct_sel_i = 0; wclk(4);
  endtask

  task automatic t_mode_ignore();
    logic [19:0] keep;
    direct_sel_i = 0; serial_sel_i = 1; wclk(4);
    keep = out_word();
    bus_i = 8'h5A; pulse(wr_main_i); pulse(wr_low_i);
    chk("R2 wr in serial", out_word(), keep);
    serial_sel_i = 0; wclk(4);
    pulse(prim_xfer_i);
    chk("R2 xfer in parallel", out_word(), keep);
  endtask

  task automatic t_enh_serial(logic [7:0] b, logic [7:0] prev);
    serial_sel_i = 1; aux_en_ni = 0; wclk(4);
    aux_wr_i = 1; wclk(4);
    ser_byte(b);
    chk("R7 hold while shifting", aux_ctrl_o, prev);
    aux_wr_i = 0; wclk(5);
    chk("R7 capture", aux_ctrl_o, b);
  endtask

  task automatic t_enh_parallel(logic [7:0] b);
    serial_sel_i = 0; wclk(4);
    bus_i = b; wclk(3);
    aux_wr_i = 1; wclk(5);
    chk("R8 rising load", aux_ctrl_o, b);
    bus_i = ~b; aux_wr_i = 0; wclk(5);
    chk("R8 no fall load", aux_ctrl_o, b);
  endtask

  task automatic t_enable(logic [7:0] b);
    aux_en_ni = 1; wclk(5);
    chk("R9 masked", aux_ctrl_o, 0);
    aux_en_ni = 0; wclk(5);
    chk("R9 unmasked", aux_ctrl_o, b);
  endtask

  task automatic t_isolation(logic [19:0] w, logic [7:0] b, logic [7:0] prev);
    serial_sel_i = 1; aux_wr_i = 0; wclk(4);
    ser_word(w);
    t_enh_serial(b, prev);
    pulse(prim_xfer_i);
    exp_w = w;
    chk("R10 primary intact", out_word(), exp_w);
  endtask

  initial begin
    exp_w = 0;
    wclk(3);
    t_reset();
    rst_ni = 1; wclk(4);
    t_reset();
    t_parallel(20'hA5C3E);
    t_parallel(20'h5A3C1);
    t_parallel(20'hFFFFF);
    t_serial(20'hC3A59);
    t_serial(20'h3569A);
    t_mode_ignore();
    t_direct(16'hB4E1);
    t_direct(16'hFFFF);
    t_enh_serial(8'hB6, 8'h00);
    t_enh_parallel(8'h3C);
    t_enable(8'h3C);
    t_enh_serial(8'h81, 8'h3C);
    t_isolation(20'h9E17B, 8'h5D, 8'h81);
    t_enable(8'h5D);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule